// File: doc/BRIEF.md
# Digital Continuously Variable Slope Delta Codec

This block is a single-channel delta modulation codec built entirely from digital logic. On every falling edge of the bit clock it makes one decision bit. In encode mode that bit comes from comparing a signed PCM input sample against the block's own reconstructed value. In decode mode it comes from an external bit stream. The same decision bit drives a short history register, a run detector, a syllabic step-size filter and a saturating integrator. The integrator output is the reconstructed signal in both modes.

The step size adapts to the signal. When the last few decision bits all agree, the run flag goes active (low) and the syllabic filter charges quickly toward a maximum step. When the bits disagree, the filter decays slowly toward a minimum step, and that minimum is never zero. In data mode the decision is the inverse of the external data bit. Tying the output back to the data input therefore forms a toggle, which puts an alternating idle pattern onto the line.

Top module: `cvsd_codec`

## Requirements
- R1: A synchronous reset, sampled on the falling edge of `bit_clk`, sets:
  - `recon_out` to 0 and `delta_out` to 0;
  - the history to an alternating pattern, with bit i equal to i mod 2, so `run_n` reads 1;
  - the step to STEP_MIN. The first step after reset therefore moves `recon_out` by exactly STEP_MIN.
- R2: In encode mode (`enc_mode`=1), after each falling edge `delta_out` is 1 if, just before that edge, `recon_out` was greater than `sample_in` as signed values, and 0 otherwise.
- R3: In data mode (`enc_mode`=0), after each falling edge `delta_out` is the inverse of the `data_in` value sampled at that edge.
- R4: `run_n` is 0 exactly when the last HIST_LEN decision bits are all equal. The reset pattern of R1 counts as the earliest bits. HIST_LEN is 3 or 4.
- R5: On each falling edge, `recon_out` becomes r - (r >>> LEAK_SHIFT) + s when the decision bit is 0, and r - (r >>> LEAK_SHIFT) - s when it is 1. Here r is the old `recon_out`, `>>>` is an arithmetic shift and s is the current step.
- R6: On an edge where `run_n` was 0, the step rises by max(1, (STEP_MAX - s) >> CHARGE_SHIFT). It never rises above STEP_MAX.
- R7: On an edge where `run_n` was 1, the step falls by max(1, (s - STEP_MIN) >> DECAY_SHIFT). It never falls below STEP_MIN.
- R8: `recon_out` saturates at the signed full-scale limits of SAMPLE_W bits and never wraps.
- R9: In data mode with `data_in` tied to `delta_out`, the output alternates on every clock and, once the history has filled, `run_n` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Bit clock; all state changes on its falling edge |
| rst | input | 1 | Synchronous reset, active high |
| enc_mode | input | 1 | 1: decision from the comparator; 0: decision from `data_in` |
| data_in | input | 1 | External delta bit, inverting toward `delta_out` |
| sample_in | input | SAMPLE_W | Signed PCM input sample (encode mode) |
| delta_out | output | 1 | Registered decision bit |
| run_n | output | 1 | Coincidence flag, low when the history bits are all equal |
| recon_out | output | SAMPLE_W | Signed reconstructed (integrator) value |

## Verification
Full-scale saturation is the hardest situation to reach from the ports. With a leaking integrator, the comparator loop settles well before the rails for ordinary inputs. The bench therefore drives data mode with a constant bit, which keeps the run flag active long enough for the step to climb to its maximum and pin the integrator at each limit in turn. The step value is never visible directly. Its charge and decay are checked through the exact size of every integrator move, against an arithmetic model in the bench, across these phases:
- a constant input;
- a triangle sweep;
- a pseudo-random decode stream;
- the toggle loop.

// File: rtl/cvsd_pkg.sv
package cvsd_pkg;
   // Source of the bit that feeds the history register and the integrator.
   typedef enum logic {
      SRC_DATA    = 1'b0,
      SRC_COMPARE = 1'b1
   } bit_src_e;

   // Alternating start pattern: bit i holds i mod 2.
   function automatic logic [7:0] alt_pattern();
      logic [7:0] p;
      for (int i = 0; i < 8; i++) p[i] = i[0];
      return p;
   endfunction
endpackage

// File: rtl/cvsd_history.sv
module cvsd_history #(
   parameter int HIST_LEN = 4
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                bit_in,
   output logic [HIST_LEN-1:0] hist_q,
   output logic                run_n
);
   localparam logic [7:0]          ALT_FULL = cvsd_pkg::alt_pattern();
   localparam logic [HIST_LEN-1:0] ALT_INIT = ALT_FULL[HIST_LEN-1:0];

   generate
      if (HIST_LEN < 3 || HIST_LEN > 4) begin : g_bad_len
         $error("cvsd_history: HIST_LEN must be 3 or 4");
      end
   endgenerate

   always_ff @(negedge clk) begin
      if (rst) hist_q <= ALT_INIT;
      else     hist_q <= {hist_q[HIST_LEN-2:0], bit_in};
   end

   always_comb run_n = !((&hist_q) || !(|hist_q));

   // R4: an active run survives only if the new bit matches the old ones
   p_run_continues_r4: assert property (@(negedge clk) disable iff (rst)
      !run_n |=> (run_n == ($past(bit_in) != $past(hist_q[0]))));
endmodule

// File: rtl/cvsd_syllabic.sv
module cvsd_syllabic #(
   parameter int STEP_W       = 10,
   parameter int STEP_MIN     = 4,
   parameter int STEP_MAX     = 512,
   parameter int CHARGE_SHIFT = 2,
   parameter int DECAY_SHIFT  = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              run,
   output logic [STEP_W-1:0] step_q
);
   localparam logic [STEP_W-1:0] SMIN = STEP_W'(STEP_MIN);
   localparam logic [STEP_W-1:0] SMAX = STEP_W'(STEP_MAX);

   generate
      if (STEP_MIN < 1 || STEP_MIN > STEP_MAX || STEP_MAX >= (1 << STEP_W)) begin : g_bad_lim
         $error("cvsd_syllabic: need 1 <= STEP_MIN <= STEP_MAX < 2**STEP_W");
      end
      if (DECAY_SHIFT < CHARGE_SHIFT) begin : g_bad_shift
         $error("cvsd_syllabic: DECAY_SHIFT must not be below CHARGE_SHIFT");
      end
   endgenerate

   logic [STEP_W-1:0] gap_up, gap_dn, inc, dec;
   logic [STEP_W:0]   up_sum;
   logic [STEP_W-1:0] step_d;

   always_comb begin
      gap_up = SMAX - step_q;
      gap_dn = step_q - SMIN;
      inc    = gap_up >> CHARGE_SHIFT;
      dec    = gap_dn >> DECAY_SHIFT;
      if (inc == '0 && gap_up != '0) inc = STEP_W'(1);
      if (dec == '0 && gap_dn != '0) dec = STEP_W'(1);
      up_sum = {1'b0, step_q} + {1'b0, inc};
      if (run) step_d = (up_sum > {1'b0, SMAX}) ? SMAX : up_sum[STEP_W-1:0];
      else     step_d = (step_q - dec < SMIN) ? SMIN : step_q - dec;
   end

   always_ff @(negedge clk) begin
      if (rst) step_q <= SMIN;
      else     step_q <= step_d;
   end

   // R6: a run below the ceiling always raises the step
   p_step_charge_r6: assert property (@(negedge clk) disable iff (rst)
      (run && step_q < SMAX) |=> (step_q > $past(step_q)));
   // R7: no run above the floor always lowers the step
   p_step_decay_r7: assert property (@(negedge clk) disable iff (rst)
      (!run && step_q > SMIN) |=> (step_q < $past(step_q)));
endmodule

// File: rtl/cvsd_integrator.sv
module cvsd_integrator #(
   parameter int SAMPLE_W   = 12,
   parameter int STEP_W     = 10,
   parameter int LEAK_SHIFT = 6
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       down,
   input  logic [STEP_W-1:0]          step,
   output logic signed [SAMPLE_W-1:0] acc_q
);
   localparam int EW = SAMPLE_W + 2;
   localparam logic signed [EW-1:0] MAXV = {3'b000, {(SAMPLE_W-1){1'b1}}};
   localparam logic signed [EW-1:0] MINV = {3'b111, {(SAMPLE_W-1){1'b0}}};

   generate
      if (STEP_W >= SAMPLE_W) begin : g_bad_step
         $error("cvsd_integrator: STEP_W must be narrower than SAMPLE_W");
      end
      if (LEAK_SHIFT < 1 || LEAK_SHIFT >= SAMPLE_W) begin : g_bad_leak
         $error("cvsd_integrator: LEAK_SHIFT out of range");
      end
   endgenerate

   logic signed [EW-1:0] acc_ext, leak, stp, wide;

   always_comb begin
      acc_ext = {{2{acc_q[SAMPLE_W-1]}}, acc_q};
      leak    = acc_ext >>> LEAK_SHIFT;
      stp     = $signed({{(EW-STEP_W){1'b0}}, step});
      wide    = acc_ext - leak + (down ? -stp : stp);
      if (wide > MAXV)      wide = MAXV;
      else if (wide < MINV) wide = MINV;
   end

   always_ff @(negedge clk) begin
      if (rst) acc_q <= '0;
      else     acc_q <= wide[SAMPLE_W-1:0];
   end

   // R1: leaving reset starts the integrator from zero
   p_reset_zero_r1: assert property (@(negedge clk) disable iff (rst)
      $past(rst) |-> (acc_q == '0));
   // R8: rising from positive never wraps negative
   p_no_wrap_up_r8: assert property (@(negedge clk) disable iff (rst)
      (!down && acc_q > 0) |=> (acc_q > 0));
   // R8: falling from negative never wraps positive
   p_no_wrap_dn_r8: assert property (@(negedge clk) disable iff (rst)
      (down && acc_q < 0) |=> (acc_q < 0));
endmodule

// File: rtl/cvsd_codec.sv
module cvsd_codec #(
   parameter int SAMPLE_W     = 12,
   parameter int HIST_LEN     = 4,
   parameter int STEP_W       = 10,
   parameter int STEP_MIN     = 4,
   parameter int STEP_MAX     = 512,
   parameter int CHARGE_SHIFT = 2,
   parameter int DECAY_SHIFT  = 5,
   parameter int LEAK_SHIFT   = 6
) (
   input  logic                       bit_clk,
   input  logic                       rst,
   input  logic                       enc_mode,
   input  logic                       data_in,
   input  logic signed [SAMPLE_W-1:0] sample_in,
   output logic                       delta_out,
   output logic                       run_n,
   output logic signed [SAMPLE_W-1:0] recon_out
);
   import cvsd_pkg::*;

   bit_src_e          src;
   logic              cmp_bit, new_bit;
   logic [HIST_LEN-1:0] hist;
   logic [STEP_W-1:0] step;

   always_comb begin
      src     = bit_src_e'(enc_mode);
      cmp_bit = (recon_out > sample_in);
      new_bit = (src == SRC_COMPARE) ? cmp_bit : !data_in;
   end

   cvsd_history #(.HIST_LEN(HIST_LEN)) u_hist (
      .clk(bit_clk), .rst(rst), .bit_in(new_bit), .hist_q(hist), .run_n(run_n)
   );

   cvsd_syllabic #(
      .STEP_W(STEP_W), .STEP_MIN(STEP_MIN), .STEP_MAX(STEP_MAX),
      .CHARGE_SHIFT(CHARGE_SHIFT), .DECAY_SHIFT(DECAY_SHIFT)
   ) u_syl (
      .clk(bit_clk), .rst(rst), .run(!run_n), .step_q(step)
   );

   cvsd_integrator #(
      .SAMPLE_W(SAMPLE_W), .STEP_W(STEP_W), .LEAK_SHIFT(LEAK_SHIFT)
   ) u_int (
      .clk(bit_clk), .rst(rst), .down(new_bit), .step(step), .acc_q(recon_out)
   );

   always_comb delta_out = hist[0];

   // R2: encode decision polarity, output high when feedback exceeds input
   p_encode_polarity_r2: assert property (@(negedge bit_clk) disable iff (rst)
      enc_mode |=> (delta_out == ($signed($past(recon_out)) > $signed($past(sample_in)))));
   // R3: data input is inverted onto the output bit
   p_data_inverts_r3: assert property (@(negedge bit_clk) disable iff (rst)
      !enc_mode |=> (delta_out != $past(data_in)));
endmodule

// File: tb/test_cvsd_codec.sv
module test_cvsd_codec;
   localparam int W = 12, L = 4, SMIN = 4, SMAX = 512, CHG = 2, DCY = 5, LEAK = 6;
   localparam int MAXV = (1 << (W-1)) - 1;
   localparam int MINV = -(1 << (W-1));

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic enc_mode = 1'b1;
   logic data_in = 1'b0;
   logic signed [W-1:0] sample_in = '0;
   logic delta_out, run_n;
   logic signed [W-1:0] recon_out;

   int n_tests = 0, n_fail = 0;
   bit done = 0;

   int m_recon, m_step, m_hist;
   bit m_delta;

   always #2 clk = ~clk;

   cvsd_codec #(.SAMPLE_W(W), .HIST_LEN(L), .STEP_MIN(SMIN), .STEP_MAX(SMAX),
                .CHARGE_SHIFT(CHG), .DECAY_SHIFT(DCY), .LEAK_SHIFT(LEAK)) i_cvsd_codec (
      .bit_clk(clk), .rst(rst), .enc_mode(enc_mode), .data_in(data_in),
      .sample_in(sample_in), .delta_out(delta_out), .run_n(run_n), .recon_out(recon_out));

   task automatic chk(input string tag, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic bit all_eq(input int h);
      int m = (1 << L) - 1;
      return ((h & m) == 0) || ((h & m) == m);
   endfunction

   task automatic model_reset();
      m_recon = 0; m_step = SMIN; m_hist = 'b1010 & ((1 << L) - 1); m_delta = 0;
   endtask

   task automatic do_reset();
      @(posedge clk); rst = 1'b1;
      @(negedge clk); @(posedge clk); @(negedge clk); #1;
      rst = 1'b0;
      model_reset();
      chk("R1 recon", recon_out, 0);
      chk("R1 delta", delta_out, 0);
      chk("R1 run_n", run_n, 1);
   endtask

   // One bit period: drive, advance model, compare after the falling edge.
   task automatic cyc(input bit m, input bit dat, input int smp, input string tag);
      bit d, run_now;
      int r, gap, amt;
      @(posedge clk);
      enc_mode = m; data_in = dat; sample_in = W'(smp);
      d = m ? (m_recon > smp) : !dat;
      run_now = all_eq(m_hist);
      r = m_recon - (m_recon >>> LEAK) + (d ? -m_step : m_step);
      if (r > MAXV) r = MAXV;
      if (r < MINV) r = MINV;
      if (run_now) begin
         gap = SMAX - m_step; amt = gap >> CHG;
         if (amt == 0 && gap != 0) amt = 1;
         m_step = m_step + amt;
      end else begin
         gap = m_step - SMIN; amt = gap >> DCY;
         if (amt == 0 && gap != 0) amt = 1;
         m_step = m_step - amt;
      end
      m_recon = r;
      m_hist = ((m_hist << 1) | d) & ((1 << L) - 1);
      m_delta = d;
      @(negedge clk); #1;
      chk(m ? "R2 delta" : "R3 delta", delta_out, m_delta);
      chk("R4 run_n", run_n, !all_eq(m_hist));
      chk(tag, recon_out, m_recon);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got %0d expected %0d", 0, 1);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      bit prev;
      logic [15:0] lfsr;
      do_reset();
      // R1: first move after reset is exactly the minimum step
      cyc(1'b0, 1'b1, 0, "R1 first step");
      chk("R1 first step size", recon_out, SMIN);
      // R6: constant high input, run of zeros charges the step
      for (int i = 0; i < 60; i++) cyc(1'b1, 1'b0, 1500, "R6 recon");
      // R7: input drops to zero, mostly alternating bits, step decays
      for (int i = 0; i < 300; i++) cyc(1'b1, 1'b0, 0, "R7 recon");
      // R2/R5: triangle sweep
      for (int i = 0; i < 256; i++) begin
         int k = i % 64;
         cyc(1'b1, 1'b0, (k < 32) ? (k*50 - 800) : ((63-k)*50 - 800), "R5 recon");
      end
      // R5: pseudo-random decode stream
      lfsr = 16'hACE1;
      for (int i = 0; i < 400; i++) begin
         cyc(1'b0, lfsr[0], 0, "R5 decode");
         lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
      end
      // R8: forced ramp to both rails
      for (int i = 0; i < 300; i++) cyc(1'b0, 1'b1, 0, "R8 up");
      chk("R8 top rail", recon_out, MAXV);
      for (int i = 0; i < 5; i++) cyc(1'b0, 1'b1, 0, "R8 hold");
      chk("R8 top rail held", recon_out, MAXV);
      for (int i = 0; i < 300; i++) cyc(1'b0, 1'b0, 0, "R8 down");
      chk("R8 bottom rail", recon_out, MINV);
      // R9: toggle loop, output fed back into data input
      prev = delta_out;
      for (int i = 0; i < 120; i++) begin
         cyc(1'b0, delta_out, 0, "R9 recon");
         chk("R9 alternates", delta_out, !prev);
         prev = delta_out;
         if (i >= L) chk("R9 no run", run_n, 1);
      end
      // R1: reset in mid-run restores the start state
      for (int i = 0; i < 10; i++) cyc(1'b0, 1'b0, 0, "R6 run");
      do_reset();
      cyc(1'b0, 1'b0, 0, "R1 first step down");
      chk("R1 first step down size", recon_out, -SMIN);
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule